// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Write-Busy Polling

This block is the receive side of a slave on a two-wire serial bus. It oversamples the clock and data lines with a fast system clock and finds the start and stop conditions. It then shifts in an addressing byte, a command byte and an optional data byte. The addressing byte carries a fixed four-bit device type code in its upper half and four strap inputs in its lower half. Each accepted byte is acknowledged by pulling the data line low through an open-drain enable. When a stop ends a transaction that carried a command, the block reports that command, and the data byte if one came, to a register bank as a one-cycle event.

Commands whose upper nibble equals a configurable opcode are treated as nonvolatile stores. A stop after such a command starts an internal busy interval, counted in system clock cycles. While the interval runs, the slave does not acknowledge its own address. A bus master can therefore poll for completion by sending start plus address repeatedly until an acknowledge comes back.

Top module: `twowire_poll_slave`

## Requirements
- R1: After reset the slave releases the data line (`sda_drive_low_o` = 0), `txn_valid_o` is 0 and `busy_o` is 0.
- R2: An addressing byte, sent most significant bit first, is acknowledged on the ninth clock only when its bits [7:4] equal 4'b0101 and its bits [3:0] equal `strap_i`.
- R3: After an addressing byte that does not match, the slave drives nothing and acknowledges no byte until the next start condition.
- R4: Bytes clocked on the bus before any start condition are not acknowledged.
- R5: Once the address matches, the command byte is acknowledged. A stop that follows raises `txn_valid_o` for exactly one cycle, with `txn_cmd_o` equal to the command and `txn_has_data_o` = 0. The event never repeats on the next cycle.
- R6: A data byte that follows the command is acknowledged. The event at the stop then shows `txn_has_data_o` = 1 and `txn_data_o` equal to that byte.
- R7: Bytes after the data byte are not acknowledged, and the command and data already received are still reported at the stop.
- R8: A stop that ends a transaction whose command has bits [7:4] equal to 4'hC holds `busy_o` high for exactly `BUSY_CYCLES` clock cycles. Other commands leave `busy_o` low. `busy_o` rises only just after a stop.
- R9: While `busy_o` is high, a matching address gets no acknowledge. After `busy_o` falls, the same address is acknowledged.
- R10: A repeated start in the middle of a transaction restarts address reception. A command received before it is discarded, and only the transaction after it is reported.
- R11: A stop that comes before any command byte has been acknowledged produces no `txn_valid_o` event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| strap_i | input | 4 | Device select straps, compared with address bits [3:0] |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| txn_valid_o | output | 1 | One-cycle event: a transaction with a command ended at a stop |
| txn_cmd_o | output | 8 | Command byte of the reported transaction |
| txn_data_o | output | 8 | Data byte of the reported transaction |
| txn_has_data_o | output | 1 | The reported transaction carried a data byte |
| busy_o | output | 1 | Internal nonvolatile write interval is running |

## Verification
The end of the busy interval and the address-acknowledge decision can land in the same cycle. The ack decision reads the busy flag at the clock-low edge after the eighth address bit, and the interval may expire right there. The bench provokes this by polling with start plus a matching address straight after a store command, and then over and over until an acknowledge returns. It judges the result two ways. The first poll must be refused while `busy_o` is high. Any poll that is acknowledged must see `busy_o` low, and the measured busy length must equal the parameter exactly. The bench also runs a full 256-value address sweep against a fixed strap setting, and checks both a matching and a near-miss address for every strap value.

// File: rtl/tw_pkg.sv
package tw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RX   = 2'd1,
      ST_ACK  = 2'd2,
      ST_SKIP = 2'd3
   } tw_state_t;

   localparam int unsigned BYTE_BITS = 8;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/tw_cond_det.sv
module tw_cond_det (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic start_o,
   output logic stop_o,
   output logic scl_rise_o,
   output logic scl_fall_o
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s_i;
         sda_d <= sda_s_i;
      end
   end

   // data edges while the clock stays high are bus conditions
   assign start_o    = scl_s_i & scl_d &  sda_d & ~sda_s_i;
   assign stop_o     = scl_s_i & scl_d & ~sda_d &  sda_s_i;
   assign scl_rise_o =  scl_s_i & ~scl_d;
   assign scl_fall_o = ~scl_s_i &  scl_d;
endmodule

// File: rtl/tw_busy_timer.sv
module tw_busy_timer #(
   parameter int unsigned CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);
   if (CYCLES == 0) begin : g_no_timer
      assign busy_o = 1'b0;
   end else begin : g_timer
      localparam int unsigned CW = $clog2(CYCLES + 1);
      localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES);
      logic [CW-1:0] remain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               remain <= '0;
         else if (load_i)          remain <= LOAD_VAL;
         else if (remain != '0)    remain <= remain - 1'b1;
      end

      assign busy_o = (remain != '0);
   end
endmodule

// File: rtl/twowire_poll_slave.sv
module twowire_poll_slave #(
   parameter logic [3:0]  TYPE_ID     = 4'b0101,
   parameter logic [3:0]  NV_OPCODE   = 4'hC,
   parameter int unsigned BUSY_CYCLES = 250000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   input  logic [3:0] strap_i,
   output logic       sda_drive_low_o,
   output logic       txn_valid_o,
   output logic [7:0] txn_cmd_o,
   output logic [7:0] txn_data_o,
   output logic       txn_has_data_o,
   output logic       busy_o
);
   import tw_pkg::*;

   localparam int unsigned BCW = $clog2(BYTE_BITS);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(BYTE_BITS - 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("twowire_poll_slave: SYNC_STAGES must be at least 2");
   end

   logic scl_s, sda_s;
   logic start_evt, stop_evt, scl_rise, scl_fall;
   tw_state_t state;
   logic [BCW-1:0] bit_cnt;
   logic byte_full;
   logic [1:0] byte_idx;
   logic [BYTE_BITS-1:0] rx_shift;
   logic [7:0] cmd_q, data_q;
   logic cmd_seen, data_seen;
   logic nv_load;
   logic addr_match;

   tw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   tw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   tw_cond_det u_det (
      .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
      .start_o(start_evt), .stop_o(stop_evt),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall));

   assign nv_load = stop_evt & cmd_seen & (cmd_q[7:4] == NV_OPCODE);

   tw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk(clk), .rst_n(rst_n), .load_i(nv_load), .busy_o(busy_o));

   assign addr_match = (rx_shift[7:4] == TYPE_ID) && (rx_shift[3:0] == strap_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state          <= ST_IDLE;
         bit_cnt        <= '0;
         byte_full      <= 1'b0;
         byte_idx       <= 2'd0;
         rx_shift       <= '0;
         cmd_q          <= '0;
         data_q         <= '0;
         cmd_seen       <= 1'b0;
         data_seen      <= 1'b0;
         txn_valid_o    <= 1'b0;
         txn_has_data_o <= 1'b0;
      end else begin
         txn_valid_o <= 1'b0;
         if (start_evt) begin
            state     <= ST_RX;
            bit_cnt   <= '0;
            byte_full <= 1'b0;
            byte_idx  <= 2'd0;
            cmd_seen  <= 1'b0;
            data_seen <= 1'b0;
         end else if (stop_evt) begin
            if (cmd_seen) begin
               txn_valid_o    <= 1'b1;
               txn_has_data_o <= data_seen;
            end
            state     <= ST_IDLE;
            cmd_seen  <= 1'b0;
            data_seen <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     rx_shift <= {rx_shift[BYTE_BITS-2:0], sda_s};
                     bit_cnt  <= bit_cnt + 1'b1;
                     if (bit_cnt == LAST_BIT) byte_full <= 1'b1;
                  end else if (scl_fall && byte_full) begin
                     byte_full <= 1'b0;
                     unique case (byte_idx)
                        2'd0: state <= (addr_match && !busy_o) ? ST_ACK : ST_IDLE;
                        2'd1: begin
                           state    <= ST_ACK;
                           cmd_q    <= rx_shift;
                           cmd_seen <= 1'b1;
                        end
                        2'd2: begin
                           state     <= ST_ACK;
                           data_q    <= rx_shift;
                           data_seen <= 1'b1;
                        end
                        default: state <= ST_SKIP;
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     state    <= ST_RX;
                     bit_cnt  <= '0;
                     byte_idx <= byte_idx + 2'd1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_drive_low_o = (state == ST_ACK);
   assign txn_cmd_o       = cmd_q;
   assign txn_data_o      = data_q;
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
   parameter logic [3:0] TYPE_ID = 4'b0101
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       stop_evt,
   input logic       sda_drive_low_o,
   input logic [1:0] byte_idx,
   input logic [7:0] rx_shift,
   input logic [3:0] strap_i,
   input logic       busy_o,
   input logic       txn_valid_o
);
   // acknowledge drive only changes while the bus clock is low
   assert_ack_edge_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low_o) |-> !scl_s);

   // address acknowledge only for the type code plus straps
   assert_addr_ack_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_drive_low_o && byte_idx == 2'd0) |-> (rx_shift[7:4] == TYPE_ID && rx_shift[3:0] == strap_i));

   // transaction event is a single-cycle pulse following a stop
   assert_txn_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid_o |=> !txn_valid_o);
   assert_txn_after_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid_o |-> $past(stop_evt));

   // busy interval starts only right after a stop
   assert_busy_from_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_evt));

   // no address acknowledge during the busy interval
   assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !(sda_drive_low_o && byte_idx == 2'd0));
endmodule

bind twowire_poll_slave tw_checker #(.TYPE_ID(TYPE_ID)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_evt(stop_evt),
   .sda_drive_low_o(sda_drive_low_o), .byte_idx(byte_idx), .rx_shift(rx_shift),
   .strap_i(strap_i), .busy_o(busy_o), .txn_valid_o(txn_valid_o));

// File: tb/sim_twowire_poll_slave.sv
`timescale 1ns/1ps
module sim_twowire_poll_slave;
   localparam int BUSY = 300;
   localparam int Q    = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic [3:0] strap = 4'h9;
   logic drv, tv, thd, busy;
   logic [7:0] tcmd, tdata;
   logic sda_line;

   int n_chk = 0;
   int n_fail = 0;
   int n_txn = 0;
   int busy_len = 0;
   logic [7:0] got_cmd, got_data;
   logic got_hd;

   always #4 clk = ~clk;

   assign sda_line = m_sda & ~drv;

   twowire_poll_slave #(.BUSY_CYCLES(BUSY)) u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(strap),
      .sda_drive_low_o(drv), .txn_valid_o(tv), .txn_cmd_o(tcmd), .txn_data_o(tdata),
      .txn_has_data_o(thd), .busy_o(busy));

   always @(negedge clk) begin
      if (tv) begin
         n_txn++;
         got_cmd  = tcmd;
         got_data = tdata;
         got_hd   = thd;
      end
      if (busy) busy_len++;
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic q_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; q_wait(Q);
      m_scl = 1'b1; q_wait(Q);
      m_sda = 1'b0; q_wait(Q);
      m_scl = 1'b0; q_wait(Q);
   endtask

   task automatic bus_stop();
      m_scl = 1'b0; q_wait(Q);
      m_sda = 1'b0; q_wait(Q);
      m_scl = 1'b1; q_wait(Q);
      m_sda = 1'b1; q_wait(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      m_scl = 1'b0; q_wait(1);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; q_wait(Q);
         m_scl = 1'b1; q_wait(2*Q);
         m_scl = 1'b0; q_wait(Q);
      end
      m_sda = 1'b1; q_wait(Q);
      m_scl = 1'b1; q_wait(Q);
      acked = (sda_line == 1'b0);
      q_wait(Q);
      m_scl = 1'b0; q_wait(Q);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic ack;
      int base;
      int polls;
      q_wait(5);
      // R1 reset state
      check("R1 drive", drv, 0);
      check("R1 valid", tv, 0);
      check("R1 busy", busy, 0);
      rst_n = 1'b1;
      q_wait(10);
      check("R1 drive after release", drv, 0);

      // R4 byte with no preceding start
      send_byte(8'h59, ack);
      check("R4 no ack without start", ack, 0);
      bus_stop();

      // R2/R3 sweep of all addresses, strap fixed at 9
      for (int a = 0; a < 256; a++) begin
         bus_start();
         send_byte(8'(a), ack);
         check("R2 addr sweep ack", ack, (a == 8'h59) ? 1 : 0);
         bus_stop();
      end
      // R2 every strap value, exact and near-miss
      for (int s = 0; s < 16; s++) begin
         strap = 4'(s);
         bus_start(); send_byte({4'b0101, 4'(s)}, ack);
         check("R2 strap match", ack, 1); bus_stop();
         bus_start(); send_byte({4'b0101, 4'(s) ^ 4'h8}, ack);
         check("R2 strap miss", ack, 0); bus_stop();
      end
      strap = 4'h9;

      // R3 mismatch stays silent for following bytes
      base = n_txn;
      bus_start(); send_byte(8'h58, ack);
      check("R3 miss addr", ack, 0);
      send_byte(8'h12, ack);
      check("R3 no ack after miss", ack, 0);
      bus_stop();
      check("R3 no txn after miss", n_txn - base, 0);

      // R5 command only, non-store
      base = n_txn; busy_len = 0;
      bus_start(); send_byte(8'h59, ack); check("R5 addr", ack, 1);
      send_byte(8'h3A, ack); check("R5 cmd ack", ack, 1);
      bus_stop();
      check("R5 one event", n_txn - base, 1);
      check("R5 cmd value", got_cmd, 8'h3A);
      check("R5 no data flag", got_hd, 0);
      check("R8 non-store no busy", busy_len, 0);

      // R6 command plus data, R7 extra byte refused
      base = n_txn;
      bus_start(); send_byte(8'h59, ack);
      send_byte(8'h21, ack); check("R6 cmd ack", ack, 1);
      send_byte(8'hB7, ack); check("R6 data ack", ack, 1);
      send_byte(8'h55, ack); check("R7 extra byte no ack", ack, 0);
      bus_stop();
      check("R7 one event", n_txn - base, 1);
      check("R6 data flag", got_hd, 1);
      check("R6 data value", got_data, 8'hB7);
      check("R7 cmd kept", got_cmd, 8'h21);

      // R11 stop after address only
      base = n_txn;
      bus_start(); send_byte(8'h59, ack); bus_stop();
      check("R11 no event", n_txn - base, 0);

      // R10 repeated start after a mismatch and after a command
      base = n_txn;
      bus_start(); send_byte(8'h5F, ack); check("R10 first miss", ack, 0);
      bus_start(); send_byte(8'h59, ack); check("R10 addr after restart", ack, 1);
      send_byte(8'h11, ack); check("R10 cmd ack", ack, 1);
      bus_start(); send_byte(8'h59, ack); check("R10 addr after mid restart", ack, 1);
      send_byte(8'h12, ack);
      bus_stop();
      check("R10 single event", n_txn - base, 1);
      check("R10 later cmd reported", got_cmd, 8'h12);

      // R8/R9 store command and polling
      busy_len = 0;
      bus_start(); send_byte(8'h59, ack);
      send_byte(8'hC3, ack); send_byte(8'h80, ack);
      bus_stop();
      check("R8 busy raised", busy, 1);
      bus_start(); send_byte(8'h59, ack);
      check("R9 first poll refused", ack, 0);
      bus_stop();
      polls = 1;
      ack = 1'b0;
      while (!ack && polls < 20) begin
         bus_start(); send_byte(8'h59, ack);
         if (ack) check("R9 ack only when idle", busy, 0);
         bus_stop();
         polls++;
      end
      check("R9 poll eventually acked", ack, 1);
      check("R8 busy length", busy_len, BUSY);

      // R8 store command without data byte
      busy_len = 0;
      bus_start(); send_byte(8'h59, ack); send_byte(8'hC0, ack); bus_stop();
      q_wait(BUSY + 20);
      check("R8 busy length no data", busy_len, BUSY);
      bus_start(); send_byte(8'h59, ack);
      check("R9 ack after busy", ack, 1);
      bus_stop();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule